// File: doc/BRIEF.md
# Oversampled Serial Receive Front End

This block turns an asynchronous serial line into characters. It uses a clock enable that pulses sixteen times per bit period. The line first passes through a synchronizer. A high-to-low transition seen between two consecutive enable pulses marks a candidate start bit. The line is sampled again at the centre of that start bit, eight pulses later. If the line is low there, the start is accepted and the receiver samples every following bit once, at its centre, sixteen pulses apart. If the line is high there, the event is a glitch and the receiver drops back to idle without producing anything.

The character format is latched when the start bit is confirmed. The format covers five to eight data bits, sent least significant bit first, an optional parity bit that can be even or odd, and one stop bit. When the stop-bit centre is reached, the block presents the right-aligned byte together with three error flags and pulses a valid strobe for one clock. The error flags report a parity mismatch, a bad stop bit and a line break. A downstream status register places the three-bit error vector at its bits 2 to 4, in the order given in R4 to R6.

Top module: `serial_rx_front`

## Requirements
- R1: While reset is asserted and after it is released, rx_valid is 0, rx_data is 0 and rx_err is 3'b000 until the first character completes.
- R2: A start is accepted only if the synchronized line is still low at the eighth enable pulse after the falling edge. If it is high there, no character is produced, the held outputs do not change, and a later well-formed character is received correctly.
- R3: word_len selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits arrive LSB first, one every sixteen enable pulses. rx_data holds them right-aligned with the unused upper bits 0.
- R4: When par_en is 1, one parity bit follows the data. par_even=1 selects even parity and 0 selects odd parity. rx_err[0] is 1 when the received parity does not match. When par_en is 0, rx_err[0] is always 0.
- R5: rx_err[1] (framing) is 1 when the stop bit is sampled as 0.
- R6: rx_err[2] (break) is 1 when every data bit, the parity bit if present, and the stop bit are all 0. A break therefore also sets rx_err[1].
- R7: rx_valid pulses for exactly one clock per character, at the stop-bit centre. rx_data and rx_err hold their values until the next character completes.
- R8: After a character whose stop bit was 0, a line that stays low produces no further characters until the line has been seen high at an enable pulse.
- R9: The receiver state advances only on clocks where tick_16x is 1. A divided enable gives the same results as an enable that is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick_16x | input | 1 | Enable at sixteen times the bit rate |
| word_len | input | 2 | Data bit count code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 for even parity, 0 for odd parity |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-clock strobe when a character completes |
| rx_err | output | 3 | {break, framing, parity} flags of the last character |

## Verification
The bench builds the block with its default parameters: an oversampling factor of 16, a two-stage synchronizer and an eight-bit data path. It mostly drives the enable high on every clock, which makes each frame short. That brings within reach every 5-bit value and a spread of 6-, 7- and 8-bit values under no parity, even parity and odd parity, with injected parity flips and bad stop bits. Separate passes cover the following:
- a short glitch that must be rejected as a false start;
- an all-zero break followed by a line held low;
- a divided enable that must give the same results.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
  } rx_cfg_t;

  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_BRK = 2;

  function automatic logic [3:0] len_to_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic at_mid,
  output logic at_end
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_mid = tick && (cnt_q == MID_CNT);
  assign at_end = tick && (cnt_q == LAST_CNT);

  // R9: count moves only on an enable pulse or a restart
  a_r9_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              par_stb,
  input  logic              bit_in,
  output logic [DATA_W-1:0] shreg,
  output logic              acc,
  output logic              all_zero
);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              acc_q, acc_d;
  logic              zero_q, zero_d;

  always_comb begin
    shreg_d = shreg_q;
    acc_d   = acc_q;
    zero_d  = zero_q;
    if (clear) begin
      shreg_d = '0;
      acc_d   = 1'b0;
      zero_d  = 1'b1;
    end else if (shift_en) begin
      shreg_d = {bit_in, shreg_q[DATA_W-1:1]};
      acc_d   = acc_q ^ bit_in;
      zero_d  = zero_q & ~bit_in;
    end else if (par_stb) begin
      acc_d   = acc_q ^ bit_in;
      zero_d  = zero_q & ~bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      acc_q   <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      shreg_q <= shreg_d;
      acc_q   <= acc_d;
      zero_q  <= zero_d;
    end
  end

  assign shreg    = shreg_q;
  assign acc      = acc_q;
  assign all_zero = zero_q;

  // R6: a one bit clears the all-zero tracker until the next clear
  a_r6_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !zero_q) |=> !zero_q);

endmodule

// File: rtl/serial_rx_front.sv
module serial_rx_front #(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick_16x,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic [2:0]        rx_err
);
  import srx_pkg::*;

  localparam int BIDX_W = $clog2(DATA_W + 1);
  localparam logic [BIDX_W-1:0] DW = BIDX_W'(DATA_W);

  logic line_s;
  logic at_mid, at_end, tmr_restart;
  logic des_clear, des_shift, des_par;
  logic [DATA_W-1:0] shreg;
  logic acc, all_zero;

  rx_state_e         state_q, state_d;
  rx_cfg_t           cfg_q, cfg_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic              prev_q, prev_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [2:0]        err_q, err_d;
  logic              valid_q, valid_d;
  logic [BIDX_W-1:0] nbits;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s));

  srx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .restart(tmr_restart),
    .at_mid(at_mid), .at_end(at_end));

  srx_deser #(.DATA_W(DATA_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .clear(des_clear), .shift_en(des_shift),
    .par_stb(des_par), .bit_in(line_s), .shreg(shreg), .acc(acc),
    .all_zero(all_zero));

  assign nbits = BIDX_W'(len_to_bits(cfg_q.len));

  always_comb begin
    state_d     = state_q;
    cfg_d       = cfg_q;
    bidx_d      = bidx_q;
    prev_d      = tick_16x ? line_s : prev_q;
    data_d      = data_q;
    err_d       = err_q;
    valid_d     = 1'b0;
    tmr_restart = 1'b0;
    des_clear   = 1'b0;
    des_shift   = 1'b0;
    des_par     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (tick_16x && prev_q && !line_s) begin
          state_d     = S_START;
          tmr_restart = 1'b1;
        end
      end
      S_START: begin
        if (at_mid) begin
          if (!line_s) begin
            state_d     = S_DATA;
            tmr_restart = 1'b1;
            des_clear   = 1'b1;
            bidx_d      = '0;
            cfg_d       = '{len: word_len, par_en: par_en, par_even: par_even};
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_DATA: begin
        if (at_end) begin
          des_shift   = 1'b1;
          tmr_restart = 1'b1;
          if (bidx_q == nbits - 1'b1) state_d = cfg_q.par_en ? S_PAR : S_STOP;
          else                        bidx_d  = bidx_q + 1'b1;
        end
      end
      S_PAR: begin
        if (at_end) begin
          des_par     = 1'b1;
          tmr_restart = 1'b1;
          state_d     = S_STOP;
        end
      end
      S_STOP: begin
        if (at_end) begin
          state_d          = S_IDLE;
          valid_d          = 1'b1;
          data_d           = shreg >> (DW - nbits);
          err_d[ERR_PAR]   = cfg_q.par_en & (acc ^ ~cfg_q.par_even);
          err_d[ERR_FRM]   = ~line_s;
          err_d[ERR_BRK]   = all_zero & ~line_s;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cfg_q   <= '0;
      bidx_q  <= '0;
      prev_q  <= 1'b0;
      data_q  <= '0;
      err_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      bidx_q  <= bidx_d;
      prev_q  <= prev_d;
      data_q  <= data_d;
      err_q   <= err_d;
      valid_q <= valid_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_err   = err_q;
  assign rx_valid = valid_q;

  // R7: strobe lasts a single clock
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9: no state change without an enable pulse
  a_r9_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_16x |=> $stable(state_q));

  // R2: high line at the start-bit centre returns to idle
  a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START && at_mid && line_s) |=> (state_q == S_IDLE));

  // R8: no new start until the line was seen high
  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !prev_q) |=> (state_q == S_IDLE));

  // R6: a break always carries a framing error
  a_r6_break_framing: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err[ERR_BRK]) |-> rx_err[ERR_FRM]);

  // R4: parity flag stays clear without parity
  a_r4_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_q.par_en) |-> !rx_err[ERR_PAR]);

  // R3: top data bit is zero for short words
  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_q.len != 2'b11) |-> !rx_data[DATA_W-1]);

endmodule

// File: tb/serial_rx_front_bench.sv
module serial_rx_front_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line;
  logic       tick_16x;
  logic [1:0] word_len;
  logic       par_en;
  logic       par_even;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic [2:0] rx_err;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_ctr = 0;
  int got_n = 0;
  logic [7:0] got_d = '0;
  logic [2:0] got_e = '0;

  always #5 clk = ~clk;

  serial_rx_front u_serial_rx_front (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick_16x(tick_16x),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err));

  always @(negedge clk) begin
    tick_16x = (tick_ctr == 0);
    tick_ctr = (tick_ctr + 1 >= tick_div) ? 0 : tick_ctr + 1;
    if (rx_valid) begin
      got_n = got_n + 1;
      got_d = rx_data;
      got_e = rx_err;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick_16x);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk);
    rx_line = v;
    wait_ticks(16);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pe,
                            input bit pev, input bit flip, input logic stopv,
                            input logic after_v);
    logic p;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pe) begin
      p = pev ? ^d : ~^d;
      send_bit(p ^ flip);
    end
    send_bit(stopv);
    send_bit(after_v);
  endtask

  task automatic frame_check(input logic [7:0] d, input int wl, input int pm,
                             input bit flip, input logic stopv);
    int n0;
    int nb;
    logic [7:0] dm;
    logic [2:0] exp_e;
    bit pe, pev;
    logic pbit;
    nb = 5 + wl;
    dm = d & 8'((1 << nb) - 1);
    pe = (pm != 0);
    pev = (pm == 1);
    pbit = pe ? ((pev ? ^dm : ~^dm) ^ flip) : 1'b0;
    @(negedge clk);
    word_len = 2'(wl);
    par_en = pe;
    par_even = pev;
    n0 = got_n;
    send_frame(dm, nb, pe, pev, flip, stopv, 1'b1);
    exp_e[0] = pe & flip;
    exp_e[1] = ~stopv;
    exp_e[2] = (dm == 0) & ~pbit & ~stopv;
    check(got_n == n0 + 1, "R7 one strobe per frame", got_n - n0, 1);
    check(got_d == dm, "R3 data bits", got_d, dm);
    check(got_e[0] == exp_e[0], "R4 parity flag", got_e, exp_e);
    check(got_e[1] == exp_e[1], "R5 framing flag", got_e, exp_e);
    check(got_e[2] == exp_e[2], "R6 break flag", got_e, exp_e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    logic [7:0] last_d;
    rst_n = 1'b0;
    rx_line = 1'b1;
    word_len = 2'b11;
    par_en = 1'b0;
    par_even = 1'b0;
    repeat (4) @(negedge clk);
    check(rx_valid == 0 && rx_data == 0 && rx_err == 0, "R1 reset state",
          {rx_valid, rx_data, rx_err}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(got_n == 0 && rx_data == 0 && rx_err == 0, "R1 idle after reset",
          got_n, 0);

    // R3 R4 R5 R6: sweep word lengths, parity modes and data values
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 3; pm++)
        for (int k = 0; k < 32; k++)
          frame_check(8'((k * 29 + wl * 7 + pm * 11 + 3) & 255), wl, pm,
                      (pm != 0) && (k % 5 == 3), (k % 7 == 6) ? 1'b0 : 1'b1);

    // R2: short glitch is rejected as a false start
    last_d = got_d;
    n0 = got_n;
    @(negedge clk);
    rx_line = 1'b0;
    wait_ticks(4);
    @(negedge clk);
    rx_line = 1'b1;
    wait_ticks(40);
    check(got_n == n0, "R2 glitch gives no character", got_n, n0);
    @(negedge clk);
    check(rx_data == last_d, "R7 data held after glitch", rx_data, last_d);
    frame_check(8'hA5, 3, 1, 1'b0, 1'b1);

    // R6 R8: break then line held low
    @(negedge clk);
    word_len = 2'b11;
    par_en = 1'b0;
    n0 = got_n;
    send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(got_n == n0 + 1, "R6 break reported once", got_n - n0, 1);
    check(got_e == 3'b110, "R6 break flags", got_e, 3'b110);
    wait_ticks(48);
    check(got_n == n0 + 1, "R8 low line gives no character", got_n - n0, 1);
    @(negedge clk);
    rx_line = 1'b1;
    wait_ticks(16);
    frame_check(8'h3C, 3, 2, 1'b0, 1'b1);

    // R9: divided enable
    tick_div = 3;
    frame_check(8'h96, 3, 1, 1'b0, 1'b1);
    frame_check(8'h1F, 0, 2, 1'b1, 1'b1);
    frame_check(8'h2A, 1, 0, 1'b0, 1'b0);
    frame_check(8'h00, 2, 1, 1'b0, 1'b0);
    check(got_e == 3'b110, "R9 break under divided enable", got_e, 3'b110);
    tick_div = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule